// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Memory Banks

This block fetches one vector of data words from a memory that is split into several banks. Consecutive word addresses map to consecutive banks. A single start pulse supplies a base word address, a stride in words and an element count. The engine then walks the addresses base, base+stride, base+2·stride and so on, and sends at most one request per clock.

Each bank stays occupied for a fixed number of cycles after it is accessed. A request whose bank is still occupied waits, and later elements wait behind it. Because of this, the total load time depends on how the stride spreads the addresses over the banks. Every bank answers a fixed number of cycles after the request. The returned words leave on a vector-register write port in element order, and a one-cycle done pulse closes the load.

The bank storage is a behavioural array inside the block. A simple fill port writes it one word at a time.

Top module: `strided_bank_loader`

## Requirements
- R1: While reset is held and after it is released with no start, `busy`, `done` and `wr_en` are all low.
- R2: Element i reads the word at address (base + i·stride) mod 2^AW. The bank is the address mod NBANKS (the low address bits) and the row is the address divided by NBANKS. A fill cycle with `fill_en` high stores `fill_data` at word `fill_addr`.
- R3: A bank accessed in issue cycle t is not accessed again before cycle t+BUSY. Requests go out in element order, one per cycle at most, and a request waits only while its own bank is occupied.
- R4: Element i appears on the write port LAT cycles after its issue cycle, with `wr_en` high, `wr_idx` = i and its word on `wr_data`. Writes come out in increasing index order, and no other cycle has `wr_en` high.
- R5: Number the issue cycles t_0 = 0 upward. `done` then rises t_last + LAT + 1 cycles after the clock edge that samples `start`. With the defaults this is 76 cycles for 64 elements at stride 1 and 391 cycles for 64 elements at stride 32.
- R6: A start with `vlen` = 0 raises `done` in the cycle right after the sampling edge. It produces no write and never raises `busy`.
- R7: A `vlen` above MAXVL is treated as MAXVL.
- R8: `busy` is high from the start edge of a non-empty load until `done` rises. A `start` seen while `busy` is high is ignored.
- R9: `done` is high for exactly one cycle per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Write one word into bank storage |
| fill_addr | input | AW | Word address for the fill write |
| fill_data | input | DW | Word written by the fill port |
| start | input | 1 | Begin a vector load (used only when idle) |
| base | input | AW | Word address of element 0 |
| stride | input | AW | Address step between elements, in words |
| vlen | input | $clog2(MAXVL+1) | Element count, 0 to MAXVL |
| busy | output | 1 | A load is in progress |
| wr_en | output | 1 | Write port valid |
| wr_idx | output | $clog2(MAXVL) | Element index of the word on the write port |
| wr_data | output | DW | Returned element |
| done | output | 1 | One-cycle pulse when the load completes |

## Verification
A wrong bank counter shows up as a write that comes out one or more cycles early or late, at the first element whose bank was reused. Every write's cycle number is compared with an issue schedule that the bench computes itself, so such an error appears at the first affected element rather than only in the final done time. A wrong address step or a wrong bank/row split appears at once as a bad word on `wr_data`, because every stored word is a distinct function of its address. Element-count errors show as a missing or extra write or a misplaced `done`, within one cycle of the expected end.

// File: rtl/svl_pkg.sv
package svl_pkg;
    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ISSUE = 2'd1,
        LD_DRAIN = 2'd2
    } ld_state_e;
endpackage

// File: rtl/bank_busy_tracker.sv
module bank_busy_tracker #(
    parameter int NBANKS = 8,
    parameter int BUSY   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_en,
    input  logic [$clog2(NBANKS)-1:0] acc_bank,
    output logic [NBANKS-1:0]         bank_busy
);
    localparam int BW = $clog2(NBANKS);
    localparam int CW = (BUSY > 1) ? $clog2(BUSY) : 1;

    logic [CW-1:0] cnt_d [NBANKS];
    logic [CW-1:0] cnt_q [NBANKS];

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        always_comb begin
            cnt_d[b] = cnt_q[b];
            if (acc_en && acc_bank == BW'(b)) begin
                cnt_d[b] = CW'(BUSY - 1);
            end else if (cnt_q[b] != '0) begin
                cnt_d[b] = cnt_q[b] - CW'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[b] <= '0;
            else        cnt_q[b] <= cnt_d[b];
        end

        assign bank_busy[b] = (cnt_q[b] != '0);
    end

    // R3
    reuse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && BUSY > 1) |=> !(acc_en && acc_bank == $past(acc_bank)));
endmodule

// File: rtl/bank_store.sv
module bank_store #(
    parameter int NBANKS = 8,
    parameter int AW     = 10,
    parameter int DW     = 32
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DW-1:0]                wr_data,
    input  logic [$clog2(NBANKS)-1:0]    rd_bank,
    input  logic [AW-$clog2(NBANKS)-1:0] rd_row,
    output logic [DW-1:0]                rd_data
);
    localparam int BW   = $clog2(NBANKS);
    localparam int ROWS = (1 << AW) / NBANKS;

    logic [DW-1:0] mem_q [NBANKS][ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr[BW-1:0]][wr_addr[AW-1:BW]] <= wr_data;
    end

    assign rd_data = mem_q[rd_bank][rd_row];
endmodule

// File: rtl/return_pipe.sv
module return_pipe #(
    parameter int LAT = 12,
    parameter int IW  = 6,
    parameter int DW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_last,
    input  logic [IW-1:0] in_idx,
    input  logic [DW-1:0] in_data,
    output logic          out_vld,
    output logic          out_last,
    output logic [IW-1:0] out_idx,
    output logic [DW-1:0] out_data
);
    typedef struct packed {
        logic          vld;
        logic          last;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
    } stage_t;

    stage_t stg_d [LAT];
    stage_t stg_q [LAT];

    always_comb begin
        stg_d[0] = '{vld: in_vld, last: in_last, idx: in_idx, data: in_data};
        for (int k = 1; k < LAT; k++) stg_d[k] = stg_q[k-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) stg_q[k] <= '0;
        end else begin
            for (int k = 0; k < LAT; k++) stg_q[k] <= stg_d[k];
        end
    end

    assign out_vld  = stg_q[LAT-1].vld;
    assign out_last = stg_q[LAT-1].last;
    assign out_idx  = stg_q[LAT-1].idx;
    assign out_data = stg_q[LAT-1].data;
endmodule

// File: rtl/strided_bank_loader.sv
module strided_bank_loader
    import svl_pkg::*;
#(
    parameter int NBANKS = 8,
    parameter int BUSY   = 6,
    parameter int LAT    = 12,
    parameter int DW     = 32,
    parameter int AW     = 10,
    parameter int MAXVL  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fill_en,
    input  logic [AW-1:0]              fill_addr,
    input  logic [DW-1:0]              fill_data,
    input  logic                       start,
    input  logic [AW-1:0]              base,
    input  logic [AW-1:0]              stride,
    input  logic [$clog2(MAXVL+1)-1:0] vlen,
    output logic                       busy,
    output logic                       wr_en,
    output logic [$clog2(MAXVL)-1:0]   wr_idx,
    output logic [DW-1:0]              wr_data,
    output logic                       done
);
    localparam int BW = $clog2(NBANKS);
    localparam int RW = AW - BW;
    localparam int LW = $clog2(MAXVL + 1);
    localparam int IW = $clog2(MAXVL);

    typedef struct packed {
        ld_state_e     st;
        logic [AW-1:0] addr;
        logic [AW-1:0] step;
        logic [LW-1:0] len;
        logic [LW-1:0] idx;
        logic          done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NBANKS-1:0] bank_busy;
    logic              issue_go;
    logic              issue_last;
    logic [BW-1:0]     cur_bank;
    logic [RW-1:0]     cur_row;
    logic [DW-1:0]     rd_data;
    logic [LW-1:0]     len_clamped;
    logic              pipe_vld;
    logic              pipe_last;

    assign cur_bank    = c_q.addr[BW-1:0];
    assign cur_row     = c_q.addr[AW-1:BW];
    assign len_clamped = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
    assign issue_last  = (c_q.idx == c_q.len - LW'(1));

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        issue_go = 1'b0;
        case (c_q.st)
            LD_IDLE: begin
                if (start) begin
                    c_d.addr = base;
                    c_d.step = stride;
                    c_d.len  = len_clamped;
                    c_d.idx  = '0;
                    if (len_clamped == '0) c_d.done = 1'b1;
                    else                   c_d.st   = LD_ISSUE;
                end
            end
            LD_ISSUE: begin
                if (!bank_busy[cur_bank]) begin
                    issue_go = 1'b1;
                    c_d.addr = c_q.addr + c_q.step;
                    c_d.idx  = c_q.idx + LW'(1);
                    if (issue_last) c_d.st = LD_DRAIN;
                end
            end
            LD_DRAIN: begin
                if (pipe_vld && pipe_last) begin
                    c_d.done = 1'b1;
                    c_d.st   = LD_IDLE;
                end
            end
            default: c_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    bank_busy_tracker #(.NBANKS(NBANKS), .BUSY(BUSY)) u_trk (
        .clk(clk), .rst_n(rst_n), .acc_en(issue_go), .acc_bank(cur_bank),
        .bank_busy(bank_busy)
    );

    bank_store #(.NBANKS(NBANKS), .AW(AW), .DW(DW)) u_mem (
        .clk(clk), .wr_en(fill_en), .wr_addr(fill_addr), .wr_data(fill_data),
        .rd_bank(cur_bank), .rd_row(cur_row), .rd_data(rd_data)
    );

    return_pipe #(.LAT(LAT), .IW(IW), .DW(DW)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_vld(issue_go), .in_last(issue_last), .in_idx(c_q.idx[IW-1:0]), .in_data(rd_data),
        .out_vld(pipe_vld), .out_last(pipe_last), .out_idx(wr_idx), .out_data(wr_data)
    );

    assign wr_en = pipe_vld;
    assign done  = c_q.done;
    assign busy  = (c_q.st != LD_IDLE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && c_q.len != '0) |-> $past(wr_en));

    // R4
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (LW'(wr_idx) < c_q.len));

    // R8
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !wr_en);
endmodule

// File: tb/strided_bank_loader_test.sv
module strided_bank_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 8;
    localparam int BUSY  = 6;
    localparam int LAT   = 12;
    localparam int DW    = 32;
    localparam int AW    = 10;
    localparam int MAXVL = 64;
    localparam int LW    = 7;
    localparam int IW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          fill_en;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic          start;
    logic [AW-1:0] base;
    logic [AW-1:0] stride;
    logic [LW-1:0] vlen;
    logic          busy, wr_en, done;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;

    strided_bank_loader #(.NBANKS(NB), .BUSY(BUSY), .LAT(LAT), .DW(DW), .AW(AW), .MAXVL(MAXVL)) uut (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
        .start(start), .base(base), .stride(stride), .vlen(vlen), .busy(busy),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] pat(int a);
        return (32'(a) * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic run_load(int b, int s, int vl, bit inject, output int done_seen);
        int n_el;
        int tl [MAXVL];
        int ready [NB];
        int t;
        int done_at;
        int next_w;
        int n;
        n_el = (vl > MAXVL) ? MAXVL : vl;
        for (int k = 0; k < NB; k++) ready[k] = 0;
        t = -1;
        for (int i = 0; i < n_el; i++) begin
            int a;
            int bk;
            a  = (b + i * s) % WORDS;
            bk = a % NB;
            t  = (t + 1 > ready[bk]) ? t + 1 : ready[bk];
            tl[i] = t;
            ready[bk] = t + BUSY;
        end
        done_at   = (n_el == 0) ? 0 : tl[n_el-1] + LAT + 1;
        done_seen = -1;
        next_w    = 0;

        @(negedge clk);
        start = 1'b1; base = AW'(b); stride = AW'(s); vlen = LW'(vl);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (n <= done_at + 3) begin
            if (wr_en) begin
                if (next_w < n_el) begin
                    logic [DW-1:0] ev;
                    ev = pat((b + next_w * s) % WORDS);
                    // R2 R4: word, index and cycle of each returned element
                    chk(n == tl[next_w] + LAT && wr_idx == IW'(next_w) && wr_data == ev,
                        "R2 R4", $sformatf("element %0d cycle/idx/data", next_w),
                        (longint'(n) << 40) | (longint'(wr_idx) << 32) | longint'(wr_data),
                        (longint'(tl[next_w] + LAT) << 40) | (longint'(next_w) << 32) | longint'(ev));
                    next_w++;
                end else begin
                    chk(1'b0, "R4", "unexpected extra write", n, -1);
                end
            end else if (next_w < n_el && n == tl[next_w] + LAT) begin
                chk(1'b0, "R4", $sformatf("missing write of element %0d", next_w), n, tl[next_w] + LAT);
                next_w++;
            end
            if (done) begin
                // R5 R6 R9
                chk(done_seen < 0 && n == done_at, "R5 R6 R9", "done cycle", n, done_at);
                done_seen = n;
            end
            if (n == 0) begin
                // R8 R6: busy right after the start edge only for non-empty loads
                chk(busy == (n_el != 0), "R8 R6", "busy after start", busy, n_el != 0);
            end
            if (inject && n == 20) begin
                start = 1'b1; base = '0; stride = AW'(1); vlen = LW'(3);
            end
            if (inject && n == 21) start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        chk(done_seen == done_at && next_w == n_el, "R5", "load completed with all elements",
            (longint'(done_seen) << 16) | next_w, (longint'(done_at) << 16) | n_el);
        chk(!busy, "R8", "idle after done", busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        int d;
        rst_n = 1'b0; fill_en = 1'b0; fill_addr = '0; fill_data = '0;
        start = 1'b0; base = '0; stride = '0; vlen = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state under reset
        chk(!busy && !done && !wr_en, "R1", "outputs in reset", {busy, done, wr_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && !wr_en, "R1", "outputs after reset", {busy, done, wr_en}, 0);

        for (int a = 0; a < WORDS; a++) begin
            fill_en = 1'b1; fill_addr = AW'(a); fill_data = pat(a);
            @(negedge clk);
        end
        fill_en = 1'b0;

        // R5: unit stride, banks rotate faster than busy time
        run_load(0, 1, 64, 1'b0, d);
        chk(d == 76, "R5", "stride 1 total", d, 76);
        // R3 R5: every access to one bank
        run_load(5, 32, 64, 1'b0, d);
        chk(d == 391, "R3 R5", "stride 32 total", d, 391);
        run_load(3, 8, 64, 1'b0, d);
        chk(d == 391, "R3 R5", "stride 8 total", d, 391);
        // R3: partial conflicts
        run_load(0, 2, 64, 1'b0, d);
        run_load(1, 4, 64, 1'b0, d);
        run_load(7, 3, 64, 1'b0, d);
        run_load(2, 5, 40, 1'b0, d);
        run_load(100, 16, 10, 1'b0, d);
        run_load(6, 0, 5, 1'b0, d);
        // R2: address wrap at top of memory
        run_load(1000, 7, 20, 1'b0, d);
        run_load(9, 1, 1, 1'b0, d);
        // R6: empty load
        run_load(4, 1, 0, 1'b0, d);
        chk(d == 0, "R6", "empty load done cycle", d, 0);
        // R7: length clamp
        run_load(0, 1, 100, 1'b0, d);
        chk(d == 76, "R7", "clamped load total", d, 76);
        // R8: start while busy ignored
        run_load(8, 2, 30, 1'b1, d);
        repeat (4) @(negedge clk);
        chk(!busy && !wr_en && !done, "R8", "no load from ignored start", {busy, wr_en, done}, 0);
        finish_run();
    end
endmodule